// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This block is a bus-master DMA engine that walks a chain of descriptors in memory. Software programs the address of the first descriptor and picks a direction. It then writes a start command. The engine reads each descriptor in turn and moves the region it names between memory and a 32-bit device data port, one word at a time. The walk ends after the descriptor that carries the end-of-chain mark.

Software can also abort a running transfer. Every outcome (normal completion, abort, memory fault and device interrupt) leaves a sticky status bit. An interrupt line is raised for the status bits that software has enabled. A hold bit in the control register keeps the engine and its status cleared while the surrounding logic is brought up.

Top module: `sg_dma_engine`

## Requirements
- R1: Registers decode at these offsets: control 0x180, status 0x184, interrupt enable 0x188 (12 bits) and chain base 0x198. The chain base reads back with bits 1:0 forced to zero. The control register reads back bit 16 (interrupt mode), bit 11 (32-bit table mode), bit 7 (hold), bit 3 (descriptor mode) and bit 2 (direction) as last written. Control bit 0 reads as 1 while the engine is active.
- R2: A descriptor is two 32-bit words, address then byte length. The first descriptor sits at the chain base and each next one follows 8 bytes later. Regions are moved in chain order.
- R3: Bit 0 of the address word marks the final descriptor and is cleared before the word is used as an address. A memory request never carries an address with bit 0 set.
- R4: Only bits 28:0 of the length word count. The engine moves ceil(length/4) 32-bit words from consecutive addresses. A zero length moves nothing, and the walk goes on.
- R5: Control bit 2 = 1 moves words from the device input port to memory. Bit 2 = 0 moves words from memory to the device output port.
- R6: A control write with bit 0 = 1, bit 1 = 0, bit 3 = 1 and bit 7 = 0 starts a walk when the engine is idle and hold is clear. A start with bit 3 clear is ignored.
- R7: After the last word of the final descriptor, status bit 6 (done) is set and status bit 0 (active) clears.
- R8: A control write with bit 1 (stop) while active ends the walk at that clock edge. Active reads 0 and status bit 1 (aborted) is set. No further memory request is issued. Stop overrides any other event in that cycle.
- R9: A memory response with the error flag sets status bit 2 and ends the walk.
- R10: While control bit 7 is set, the engine is idle, every status bit reads 0, irq is 0 and start commands are ignored.
- R11: Status bits 1, 2, 4 and 6 are sticky and are cleared by writing 1 to them at 0x184. A device interrupt pulse sets bit 4. When a set and a clear of the same bit fall in one cycle, the set wins. Bit 11 follows the link interrupt input. Bits 3, 5 and 7 to 10 read 0.
- R12: irq is high when any status bit in 11:0 is set together with the enable bit at the same position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Response; a transfer completes when mem_req and mem_ack are both high |
| mem_err | input | 1 | Error flag, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| dev_in_valid | input | 1 | Device input word available |
| dev_in_data | input | 32 | Device input word |
| dev_in_ready | output | 1 | Engine takes the device input word |
| dev_out_valid | output | 1 | Engine offers a word to the device |
| dev_out_data | output | 32 | Word for the device |
| dev_out_ready | input | 1 | Device takes the offered word |
| dev_irq | input | 1 | Device interrupt pulse |
| link_irq | input | 1 | Link interrupt summary level |
| irq | output | 1 | Enabled-status interrupt |

## Verification
The device-interrupt bit has two sources: the device interrupt pulse sets it and a write-one-to-clear from software clears it, and both can land on the same clock edge. The bench drives dev_irq high in the same cycle as a status write that clears bit 4. The bit must still read 1 afterwards, and a later lone clear must bring it to 0. Stop is likewise written while words are moving, and it must win over the beat in progress.

// File: rtl/sg_dma_engine.sv
module sg_dma_engine #(
  parameter int RAW  = 12,
  parameter int LENW = 29
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [31:0]     mem_rdata,
  input  logic            dev_in_valid,
  input  logic [31:0]     dev_in_data,
  output logic            dev_in_ready,
  output logic            dev_out_valid,
  output logic [31:0]     dev_out_data,
  input  logic            dev_out_ready,
  input  logic            dev_irq,
  input  logic            link_irq,
  output logic            irq
);
  localparam logic [RAW-1:0] A_CTL = RAW'('h180);
  localparam logic [RAW-1:0] A_STA = RAW'('h184);
  localparam logic [RAW-1:0] A_IEN = RAW'('h188);
  localparam logic [RAW-1:0] A_TBL = RAW'('h198);

  typedef enum logic [2:0] {S_IDLE, S_DADR, S_DLEN, S_PULL, S_MWR, S_MRD, S_PUSH} st_t;
  st_t st;

  logic c_rw, c_desc, c_hold, c_wide, c_ism;
  logic [11:0] ien;
  logic [31:0] tbl, ptr, buf_a, beat;
  logic [LENW-1:0] rem;
  logic last, nend, err, devint, dnend;

  wire act      = st != S_IDLE;
  wire ctl_wr   = reg_wr && reg_addr == A_CTL;
  wire sta_wr   = reg_wr && reg_addr == A_STA;
  wire hold_now = c_hold || (ctl_wr && reg_wdata[7]);
  wire stop_req = ctl_wr && reg_wdata[1] && act;
  wire go       = ctl_wr && reg_wdata[0] && !reg_wdata[1] && reg_wdata[3] && !hold_now && !act;
  wire lastbeat = rem <= LENW'(4);
  wire [LENW-1:0] new_len = mem_rdata[LENW-1:0];

  wire [31:0] sta_w = {20'd0, link_irq && !c_hold, 4'd0, dnend, 1'b0, devint, 1'b0, err, nend, act};
  wire [31:0] ctl_w = {15'd0, c_ism, 4'd0, c_wide, 3'd0, c_hold, 3'd0, c_desc, c_rw, 1'b0, act};

  assign mem_req       = st == S_DADR || st == S_DLEN || st == S_MWR || st == S_MRD;
  assign mem_we        = st == S_MWR;
  assign mem_addr      = (st == S_DADR || st == S_DLEN) ? ptr : buf_a;
  assign mem_wdata     = beat;
  assign dev_in_ready  = st == S_PULL;
  assign dev_out_valid = st == S_PUSH;
  assign dev_out_data  = beat;
  assign irq           = |(sta_w[11:0] & ien);

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = ctl_w;
      A_STA:   reg_rdata = sta_w;
      A_IEN:   reg_rdata = {20'd0, ien};
      A_TBL:   reg_rdata = tbl;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {c_rw, c_desc, c_hold, c_wide, c_ism} <= '0;
      ien <= '0; tbl <= '0; ptr <= '0; buf_a <= '0; beat <= '0; rem <= '0;
      {last, nend, err, devint, dnend} <= '0;
    end else begin
      if (ctl_wr) begin
        c_ism  <= reg_wdata[16];
        c_wide <= reg_wdata[11];
        c_hold <= reg_wdata[7];
        c_desc <= reg_wdata[3];
        c_rw   <= reg_wdata[2];
      end
      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[11:0];
      if (reg_wr && reg_addr == A_TBL) tbl <= {reg_wdata[31:2], 2'b00};
      if (sta_wr) begin
        if (reg_wdata[1]) nend   <= 1'b0;
        if (reg_wdata[2]) err    <= 1'b0;
        if (reg_wdata[4]) devint <= 1'b0;
        if (reg_wdata[6]) dnend  <= 1'b0;
      end
      if (dev_irq) devint <= 1'b1;

      case (st)
        S_IDLE: if (go) begin ptr <= tbl; st <= S_DADR; end
        S_DADR: if (mem_ack) begin
          if (mem_err) begin err <= 1'b1; st <= S_IDLE; end
          else begin
            buf_a <= {mem_rdata[31:1], 1'b0};
            last  <= mem_rdata[0];
            ptr   <= ptr + 32'd4;
            st    <= S_DLEN;
          end
        end
        S_DLEN: if (mem_ack) begin
          if (mem_err) begin err <= 1'b1; st <= S_IDLE; end
          else begin
            rem <= new_len;
            ptr <= ptr + 32'd4;
            if (new_len != '0)  st <= c_rw ? S_PULL : S_MRD;
            else if (last)      begin dnend <= 1'b1; st <= S_IDLE; end
            else                st <= S_DADR;
          end
        end
        S_PULL: if (dev_in_valid) begin beat <= dev_in_data; st <= S_MWR; end
        S_MRD: if (mem_ack) begin
          if (mem_err) begin err <= 1'b1; st <= S_IDLE; end
          else begin beat <= mem_rdata; st <= S_PUSH; end
        end
        S_MWR, S_PUSH: if (st == S_MWR ? mem_ack : dev_out_ready) begin
          if (st == S_MWR && mem_err) begin err <= 1'b1; st <= S_IDLE; end
          else begin
            buf_a <= buf_a + 32'd4;
            rem   <= lastbeat ? '0 : rem - LENW'(4);
            if (!lastbeat)  st <= c_rw ? S_PULL : S_MRD;
            else if (last)  begin dnend <= 1'b1; st <= S_IDLE; end
            else            st <= S_DADR;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (stop_req) begin
        nend <= 1'b1;
        st   <= S_IDLE;
      end
      if (hold_now) begin
        st <= S_IDLE;
        {last, nend, err, devint, dnend} <= '0;
        ptr <= '0; buf_a <= '0; beat <= '0; rem <= '0;
      end
    end
  end
endmodule

module sg_dma_chk #(
  parameter int RAW = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic [31:0]    reg_wdata,
  input logic           mem_req,
  input logic [31:0]    mem_addr,
  input logic           mem_ack,
  input logic           mem_err,
  input logic           hold,
  input logic [31:0]    sta
);
  wire ctl_wr = reg_wr && reg_addr == RAW'('h180);

  a_r8_stop_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[1] && !reg_wdata[7] && !hold && sta[0]) |=> (!sta[0] && sta[1] && !mem_req));

  a_r3_addr_masked: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);

  a_r10_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> sta == 32'd0);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sta[6]) |-> !sta[0]);

  a_r9_err_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !reg_wr && !hold) |=> (!sta[0] && sta[2]));
endmodule

bind sg_dma_engine sg_dma_chk #(.RAW(RAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
  .hold(c_hold), .sta(sta_w)
);

// File: tb/test_sg_dma_engine.sv
`timescale 1ns/1ps
module test_sg_dma_engine;
  localparam int RAW = 12;
  localparam logic [RAW-1:0] CTL = 12'h180, STA = 12'h184, IEN = 12'h188, TBL = 12'h198;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [RAW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic dev_in_ready, dev_out_valid;
  logic [31:0] dev_in_data, dev_out_data;
  logic dev_irq = 0, link_irq = 0, irq;

  always #2 clk = ~clk;

  logic [31:0] mem [0:1023];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic poke_en = 0;
  logic [31:0] poke_a = '0, poke_d = '0;
  int wcount = 0, src_cnt = 0, sink_n = 0;
  logic [31:0] sink [0:15];

  assign dev_in_data = 32'hA000_0000 + src_cnt;

  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_err   <= mem_req && !mem_ack && mem_addr == err_addr;
    mem_rdata <= mem[mem_addr[11:2]];
    if (mem_req && mem_ack && mem_we) begin
      mem[mem_addr[11:2]] <= mem_wdata;
      wcount <= wcount + 1;
    end
    if (poke_en) mem[poke_a[11:2]] <= poke_d;
    if (dev_in_ready) src_cnt <= src_cnt + 1;
    if (dev_out_valid) begin
      sink[sink_n[3:0]] <= dev_out_data;
      sink_n <= sink_n + 1;
    end
  end

  sg_dma_engine #(.RAW(RAW)) i_sg_dma_engine (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_err, .mem_rdata,
    .dev_in_valid(1'b1), .dev_in_data, .dev_in_ready,
    .dev_out_valid, .dev_out_data, .dev_out_ready(1'b1),
    .dev_irq, .link_irq, .irq
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [RAW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [RAW-1:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic poke(logic [31:0] a, logic [31:0] d);
    @(negedge clk); poke_en = 1; poke_a = a; poke_d = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); rd(STA, s);
      if (!s[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(STA, v); chk("R10 status at reset", v, 0);
    rd(CTL, v); chk("R1 control at reset", v, 0);
    chk("R12 irq at reset", {31'd0, irq}, 0);
    wr(TBL, 32'h0000_0103); rd(TBL, v); chk("R1 base readback", v, 32'h100);
  endtask

  task automatic t_mem_to_dev();
    logic [31:0] v; int n0;
    poke(32'h100, 32'h400); poke(32'h104, 8);
    poke(32'h108, 32'h501); poke(32'h10C, 4);
    poke(32'h400, 32'h11); poke(32'h404, 32'h22); poke(32'h500, 32'h33);
    wr(STA, 32'hFFF); n0 = sink_n;
    wr(TBL, 32'h100); wr(CTL, 32'h809);
    rd(CTL, v); chk("R6 start reads active", v & 32'hFFF, 32'h809);
    wait_idle();
    chk("R2 word count", sink_n - n0, 3);
    chk("R2 first word", sink[n0[3:0]], 32'h11);
    chk("R2 second word", sink[4'(n0 + 1)], 32'h22);
    chk("R3 masked address word", sink[4'(n0 + 2)], 32'h33);
    rd(STA, v); chk("R7 done set active clear", v, 32'h40);
    rd(CTL, v); chk("R6 start cleared at end", v[0], 0);
  endtask

  task automatic t_dev_to_mem();
    logic [31:0] v; int s0, w0;
    poke(32'h200, 32'h601); poke(32'h204, 32'hE000_0006); poke(32'h608, 32'hDEAD);
    wr(STA, 32'hFFF); s0 = src_cnt; w0 = wcount;
    wr(TBL, 32'h200); wr(CTL, 32'h80D);
    wait_idle();
    chk("R4 length 6 gives two words", wcount - w0, 2);
    chk("R5 word 0 to memory", mem[384], 32'hA000_0000 + s0);
    chk("R5 word 1 to memory", mem[385], 32'hA000_0000 + s0 + 1);
    chk("R4 next word untouched", mem[386], 32'hDEAD);
    rd(STA, v); chk("R7 done after dev-to-mem", v, 32'h40);
  endtask

  task automatic t_zero_len();
    int n0;
    poke(32'h300, 32'h700); poke(32'h304, 0);
    poke(32'h308, 32'h711); poke(32'h30C, 4); poke(32'h710, 32'h55);
    wr(STA, 32'hFFF); n0 = sink_n;
    wr(TBL, 32'h300); wr(CTL, 32'h809);
    wait_idle();
    chk("R4 zero length skipped", sink_n - n0, 1);
    chk("R4 word after zero length", sink[n0[3:0]], 32'h55);
  endtask

  task automatic t_stop();
    logic [31:0] v; int w0;
    poke(32'h380, 32'h801); poke(32'h384, 32'h400);
    wr(STA, 32'hFFF);
    wr(TBL, 32'h380); wr(CTL, 32'h80D);
    repeat (20) @(negedge clk);
    wr(CTL, 32'h80E);
    rd(STA, v); chk("R8 stop ends walk", v, 32'h2);
    chk("R8 no request after stop", {31'd0, mem_req}, 0);
    w0 = wcount;
    repeat (10) @(negedge clk);
    chk("R8 no writes after stop", wcount - w0, 0);
    chk("R8 stopped early", {31'd0, wcount < 300}, 1);
  endtask

  task automatic t_err();
    logic [31:0] v; int n0;
    wr(STA, 32'hFFF); n0 = sink_n;
    err_addr = 32'h3A0;
    wr(TBL, 32'h3A0); wr(CTL, 32'h809);
    wait_idle();
    rd(STA, v); chk("R9 error flagged", v, 32'h4);
    chk("R9 no data moved", sink_n - n0, 0);
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(STA, 32'hFFF); wr(IEN, 32'h40);
    wr(TBL, 32'h100); wr(CTL, 32'h809);
    wait_idle();
    chk("R12 irq on enabled done", {31'd0, irq}, 1);
    wr(STA, 32'h40);
    rd(STA, v); chk("R11 done cleared by write", v, 0);
    chk("R12 irq drops", {31'd0, irq}, 0);
    link_irq = 1; #1;
    rd(STA, v); chk("R11 link bit follows input", v, 32'h800);
    chk("R12 link masked", {31'd0, irq}, 0);
    wr(IEN, 32'h800);
    chk("R12 link enabled", {31'd0, irq}, 1);
    link_irq = 0; wr(IEN, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    @(negedge clk); dev_irq = 1; reg_wr = 1; reg_addr = STA; reg_wdata = 32'h10;
    @(negedge clk); dev_irq = 0; reg_wr = 0;
    rd(STA, v); chk("R11 set wins over clear", v, 32'h10);
    wr(STA, 32'h10);
    rd(STA, v); chk("R11 lone clear", v, 0);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
    link_irq = 1; wr(IEN, 32'hFFF);
    wr(CTL, 32'h88);
    rd(STA, v); chk("R10 hold zeroes status", v, 0);
    chk("R10 hold zeroes irq", {31'd0, irq}, 0);
    rd(CTL, v); chk("R1 hold bit readback", v, 32'h88);
    wr(TBL, 32'h100); wr(CTL, 32'h89);
    repeat (4) @(negedge clk);
    chk("R10 start ignored in hold", {31'd0, mem_req}, 0);
    wr(CTL, 32'h08); link_irq = 0; wr(IEN, 0);
    rd(STA, v); chk("R10 idle after release", v[0], 0);
  endtask

  task automatic t_no_desc_mode();
    logic [31:0] v;
    wr(STA, 32'hFFF); wr(TBL, 32'h100); wr(CTL, 32'h001);
    repeat (4) @(negedge clk);
    rd(STA, v); chk("R6 start without descriptor mode ignored", v[0], 0);
    chk("R6 no request", {31'd0, mem_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_mem_to_dev();
    t_dev_to_mem();
    t_zero_len();
    t_stop();
    t_err();
    t_irq();
    t_race();
    t_hold();
    t_no_desc_mode();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule